// File: doc/BRIEF.md
# Communication Link Session Controller

This block sequences a point-to-point communication link through its whole life: a wait for a start command, a handshake phase, an active data session and a shutdown phase that must finish before the link can be started again. It is a Moore machine with four states. The state sits in a register clocked on the rising edge, and the next-state decode and the pulse logic are separate combinational pieces. All command and status inputs are taken as already synchronised to the clock and free of bounce.

The current phase drives a four-lamp status bus in which exactly one lamp is lit. Two single-cycle strobes mark the moment a data session opens and the moment the link is back at rest. A handshake that never completes is not allowed to hang the link. A run-time limit, given in clock cycles, bounds the time spent in the handshake phase. When it runs out, the controller goes to shutdown.

Top module: `link_session_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the controller at rest on the first clock edge where it is sampled high. Afterwards `lamp` is 4'b0001 and both `sess_open` and `sess_close` are 0.
- R2: At rest (`lamp` = 4'b0001) the controller stays put while `start_cmd` is low. At the clock edge where `start_cmd` is high it moves to the handshake phase (`lamp` = 4'b0010).
- R3: In the handshake phase, a clock edge with `link_ok` high moves the controller to the data session (`lamp` = 4'b0100). `sess_open` is high for exactly the first cycle of the session.
- R4: The handshake phase lasts at most `hs_limit` cycles. If `link_ok` is still low in the last of them, the next edge moves to shutdown (`lamp` = 4'b1000). If `link_ok` is high in that last cycle, the session still opens.
- R5: In the data session the controller moves to shutdown at the edge where `xfer_done` or `abort_req` is high. Otherwise it stays in the session.
- R6: In shutdown the controller stays until `term_done` is high. That edge returns it to rest, and `sess_close` is high for exactly the first cycle back at rest.
- R7: `lamp` always has exactly one bit set when reset is low.
- R8: Inputs that do not belong to the current phase have no effect. Examples are `link_ok`, `xfer_done` and `term_done` at rest, and `start_cmd` or `term_done` during the session.
- R9: An `hs_limit` of 0 behaves like 1: a handshake that does not succeed in its first cycle goes to shutdown on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_cmd | input | 1 | Request to bring the link up |
| link_ok | input | 1 | Handshake has succeeded |
| xfer_done | input | 1 | Payload session finished normally |
| abort_req | input | 1 | Request to end the session early |
| term_done | input | 1 | Shutdown sequence has completed |
| hs_limit | input | CNT_W | Maximum handshake duration in cycles |
| lamp | output | 4 | One-hot phase: bit0 rest, bit1 handshake, bit2 session, bit3 shutdown |
| sess_open | output | 1 | One-cycle strobe on the first session cycle |
| sess_close | output | 1 | One-cycle strobe on the first cycle back at rest |

## Verification
The timeout properties assume that `hs_limit` does not change while the controller is in the handshake phase, because the checker compares its own cycle count against the live value. The bench changes `hs_limit` only while the controller is at rest. The properties also assume that every input is a clean level, sampled once per clock. The bench drives all inputs on the falling edge, so each value is stable across the rising edge that samples it.

// File: rtl/link_session_pkg.sv
package link_session_pkg;

  localparam int unsigned NUM_PHASES = 4;

  typedef logic [NUM_PHASES-1:0] phase_t;

  // One-hot codes; bit positions match the lamp bus.
  localparam phase_t PH_REST  = 4'b0001;
  localparam phase_t PH_HSHK  = 4'b0010;
  localparam phase_t PH_SESS  = 4'b0100;
  localparam phase_t PH_SHUT  = 4'b1000;

endpackage

// File: rtl/lsc_hs_timer.sv
module lsc_hs_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_hshk,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] elapsed_q;

  // Counts cycles already spent in the handshake phase.
  always_ff @(posedge clk) begin
    if (rst || !in_hshk) begin
      elapsed_q <= '0;
    end else if (elapsed_q != CNT_MAX) begin
      elapsed_q <= elapsed_q + 1'b1;
    end
  end

  // Current cycle is the last allowed one; a zero limit acts as one.
  logic [CNT_W:0] next_count;
  assign next_count = {1'b0, elapsed_q} + {{CNT_W{1'b0}}, 1'b1};
  assign expired    = in_hshk && (next_count >= {1'b0, limit});

endmodule

// File: rtl/lsc_next_phase.sv
module lsc_next_phase
  import link_session_pkg::*;
(
  input  phase_t cur,
  input  logic   start_cmd,
  input  logic   link_ok,
  input  logic   hs_expired,
  input  logic   xfer_done,
  input  logic   abort_req,
  input  logic   term_done,
  output phase_t nxt
);

  always_comb begin
    unique case (cur)
      PH_REST: nxt = start_cmd ? PH_HSHK : PH_REST;
      PH_HSHK: begin
        if (link_ok)         nxt = PH_SESS;
        else if (hs_expired) nxt = PH_SHUT;
        else                 nxt = PH_HSHK;
      end
      PH_SESS: nxt = (xfer_done || abort_req) ? PH_SHUT : PH_SESS;
      PH_SHUT: nxt = term_done ? PH_REST : PH_SHUT;
      default: nxt = PH_REST;  // any non-one-hot code recovers
    endcase
  end

endmodule

// File: rtl/lsc_strobes.sv
module lsc_strobes
  import link_session_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_t cur,
  input  phase_t nxt,
  output logic   open_q,
  output logic   close_q
);

  logic open_d;
  logic close_d;

  assign open_d  = (nxt == PH_SESS) && (cur == PH_HSHK);
  assign close_d = (nxt == PH_REST) && (cur == PH_SHUT);

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q  <= 1'b0;
      close_q <= 1'b0;
    end else begin
      open_q  <= open_d;
      close_q <= close_d;
    end
  end

endmodule

// File: rtl/link_session_ctrl.sv
module link_session_ctrl
  import link_session_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_cmd,
  input  logic             link_ok,
  input  logic             xfer_done,
  input  logic             abort_req,
  input  logic             term_done,
  input  logic [CNT_W-1:0] hs_limit,
  output logic [3:0]       lamp,
  output logic             sess_open,
  output logic             sess_close
);

  phase_t phase_q;
  phase_t phase_d;
  logic   hs_expired;

  lsc_hs_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .in_hshk (phase_q == PH_HSHK),
    .limit   (hs_limit),
    .expired (hs_expired)
  );

  lsc_next_phase u_next (
    .cur        (phase_q),
    .start_cmd  (start_cmd),
    .link_ok    (link_ok),
    .hs_expired (hs_expired),
    .xfer_done  (xfer_done),
    .abort_req  (abort_req),
    .term_done  (term_done),
    .nxt        (phase_d)
  );

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_REST;
    else     phase_q <= phase_d;
  end

  lsc_strobes u_strobes (
    .clk     (clk),
    .rst     (rst),
    .cur     (phase_q),
    .nxt     (phase_d),
    .open_q  (sess_open),
    .close_q (sess_close)
  );

  assign lamp = phase_q;

endmodule

// File: rtl/lsc_checker.sv
module lsc_checker #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start_cmd,
  input logic             link_ok,
  input logic             xfer_done,
  input logic             abort_req,
  input logic             term_done,
  input logic [CNT_W-1:0] hs_limit,
  input logic [3:0]       lamp,
  input logic             sess_open,
  input logic             sess_close
);

  logic [CNT_W-1:0] seen_q;
  logic             last_slot;

  always_ff @(posedge clk) begin
    if (rst || lamp != 4'b0010) seen_q <= '0;
    else if (seen_q != {CNT_W{1'b1}}) seen_q <= seen_q + 1'b1;
  end

  assign last_slot = ({1'b0, seen_q} + 1'b1) >= {1'b0, hs_limit};

  a_r7_lamp_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot(lamp));

  a_r2_rest_hold: assert property (@(posedge clk) disable iff (rst)
    (lamp == 4'b0001 && !start_cmd) |=> lamp == 4'b0001);

  a_r2_rest_leave: assert property (@(posedge clk) disable iff (rst)
    (lamp == 4'b0001 && start_cmd) |=> lamp == 4'b0010);

  a_r3_open: assert property (@(posedge clk) disable iff (rst)
    (lamp == 4'b0010 && link_ok) |=> (lamp == 4'b0100 && sess_open));

  a_r3_open_single: assert property (@(posedge clk) disable iff (rst)
    sess_open |=> !sess_open);

  a_r4_timeout: assert property (@(posedge clk) disable iff (rst)
    (lamp == 4'b0010 && !link_ok && last_slot) |=> lamp == 4'b1000);

  a_r4_no_early: assert property (@(posedge clk) disable iff (rst)
    (lamp == 4'b0010 && !link_ok && !last_slot) |=> lamp == 4'b0010);

  a_r5_end_session: assert property (@(posedge clk) disable iff (rst)
    (lamp == 4'b0100 && (xfer_done || abort_req)) |=> lamp == 4'b1000);

  a_r8_session_hold: assert property (@(posedge clk) disable iff (rst)
    (lamp == 4'b0100 && !xfer_done && !abort_req) |=> lamp == 4'b0100);

  a_r6_close: assert property (@(posedge clk) disable iff (rst)
    (lamp == 4'b1000 && term_done) |=> (lamp == 4'b0001 && sess_close));

  a_r6_close_single: assert property (@(posedge clk) disable iff (rst)
    sess_close |=> !sess_close);

endmodule

bind link_session_ctrl lsc_checker #(.CNT_W(CNT_W)) u_lsc_checker (
  .clk        (clk),
  .rst        (rst),
  .start_cmd  (start_cmd),
  .link_ok    (link_ok),
  .xfer_done  (xfer_done),
  .abort_req  (abort_req),
  .term_done  (term_done),
  .hs_limit   (hs_limit),
  .lamp       (lamp),
  .sess_open  (sess_open),
  .sess_close (sess_close)
);

// File: tb/test_link_session_ctrl.sv
module test_link_session_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;
  localparam logic [3:0] L_REST = 4'b0001;
  localparam logic [3:0] L_HSHK = 4'b0010;
  localparam logic [3:0] L_SESS = 4'b0100;
  localparam logic [3:0] L_SHUT = 4'b1000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_cmd = 1'b0;
  logic             link_ok = 1'b0;
  logic             xfer_done = 1'b0;
  logic             abort_req = 1'b0;
  logic             term_done = 1'b0;
  logic [CNT_W-1:0] hs_limit = 8'd6;
  logic [3:0]       lamp;
  logic             sess_open;
  logic             sess_close;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_session_ctrl #(.CNT_W(CNT_W)) i_link_session_ctrl (
    .clk(clk), .rst(rst), .start_cmd(start_cmd), .link_ok(link_ok),
    .xfer_done(xfer_done), .abort_req(abort_req), .term_done(term_done),
    .hs_limit(hs_limit), .lamp(lamp), .sess_open(sess_open),
    .sess_close(sess_close)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    start_cmd = 0; link_ok = 0; xfer_done = 0; abort_req = 0; term_done = 0;
  endtask

  task automatic expect_out(input string req, input logic [3:0] e_lamp,
                            input logic e_open, input logic e_close);
    checks++;
    if (lamp !== e_lamp || sess_open !== e_open || sess_close !== e_close
        || $countones(lamp) != 1) begin
      failures++;
      $display("FAIL %s: lamp=%b open=%b close=%b expected lamp=%b open=%b close=%b",
               req, lamp, sess_open, sess_close, e_lamp, e_open, e_close);
    end
  endtask

  // R1
  task automatic t_reset();
    idle_inputs();
    rst = 1; tick(); tick();
    expect_out("R1 in reset", L_REST, 0, 0);
    rst = 0; tick();
    expect_out("R1 after reset", L_REST, 0, 0);
  endtask

  // R2, R8: rest ignores foreign inputs, leaves on start
  task automatic t_rest();
    link_ok = 1; xfer_done = 1; term_done = 1; abort_req = 1; tick();
    expect_out("R8 rest ignores others", L_REST, 0, 0);
    idle_inputs(); tick(); tick();
    expect_out("R2 rest holds", L_REST, 0, 0);
    start_cmd = 1; tick(); start_cmd = 0;
    expect_out("R2 start to handshake", L_HSHK, 0, 0);
  endtask

  // R3, R5, R6, R8: full lifecycle, normal completion
  task automatic t_full_cycle();
    hs_limit = 8'd6;
    t_rest();
    tick();
    expect_out("R4 handshake waits", L_HSHK, 0, 0);
    link_ok = 1; tick(); link_ok = 0;
    expect_out("R3 session opens", L_SESS, 1, 0);
    start_cmd = 1; term_done = 1; tick(); idle_inputs();
    expect_out("R8 session ignores start/term_done", L_SESS, 0, 0);
    tick();
    expect_out("R5 session holds", L_SESS, 0, 0);
    xfer_done = 1; tick(); xfer_done = 0;
    expect_out("R5 done to shutdown", L_SHUT, 0, 0);
    tick(); tick();
    expect_out("R6 shutdown waits", L_SHUT, 0, 0);
    term_done = 1; tick(); term_done = 0;
    expect_out("R6 back to rest with close", L_REST, 0, 1);
    tick();
    expect_out("R6 close is one cycle", L_REST, 0, 0);
  endtask

  // R5 abort path
  task automatic t_abort();
    start_cmd = 1; tick(); start_cmd = 0;
    link_ok = 1; tick(); link_ok = 0;
    expect_out("R3 open again", L_SESS, 1, 0);
    abort_req = 1; tick(); abort_req = 0;
    expect_out("R5 abort to shutdown", L_SHUT, 0, 0);
    term_done = 1; tick(); term_done = 0;
    expect_out("R6 close after abort", L_REST, 0, 1);
  endtask

  // R4 timeout after lim cycles
  task automatic t_timeout(input int lim);
    hs_limit = lim[CNT_W-1:0];
    start_cmd = 1; tick(); start_cmd = 0;
    for (int k = 1; k < lim; k++) begin
      tick();
      expect_out("R4 no early timeout", L_HSHK, 0, 0);
    end
    tick();
    expect_out("R4 timeout to shutdown", L_SHUT, 0, 0);
    term_done = 1; tick(); term_done = 0;
    expect_out("R6 close after timeout", L_REST, 0, 1);
  endtask

  // R4 link on last allowed cycle still opens
  task automatic t_late_link(input int lim);
    hs_limit = lim[CNT_W-1:0];
    start_cmd = 1; tick(); start_cmd = 0;
    for (int k = 1; k < lim; k++) tick();
    expect_out("R4 still in handshake on last cycle", L_HSHK, 0, 0);
    link_ok = 1; tick(); link_ok = 0;
    expect_out("R4 link on last cycle opens", L_SESS, 1, 0);
    xfer_done = 1; tick(); xfer_done = 0;
    term_done = 1; tick(); term_done = 0;
    expect_out("R6 close after late link", L_REST, 0, 1);
  endtask

  // R9 zero limit
  task automatic t_zero_limit();
    hs_limit = '0;
    start_cmd = 1; tick(); start_cmd = 0;
    expect_out("R9 enter handshake", L_HSHK, 0, 0);
    tick();
    expect_out("R9 zero limit acts as one", L_SHUT, 0, 0);
    term_done = 1; tick(); term_done = 0;
    expect_out("R9 return to rest", L_REST, 0, 1);
  endtask

  // R1 reset mid-session
  task automatic t_reset_mid();
    hs_limit = 8'd6;
    start_cmd = 1; tick(); start_cmd = 0;
    link_ok = 1; tick(); link_ok = 0;
    rst = 1; tick(); rst = 0;
    expect_out("R1 reset from session", L_REST, 0, 0);
    tick();
    expect_out("R1 rest holds after reset", L_REST, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_full_cycle();
    t_abort();
    t_timeout(5);
    t_timeout(1);
    t_late_link(4);
    t_zero_limit();
    t_reset_mid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule